// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block decides when an I2C target holds SCL low and which interrupt flags go with each hold. It follows SCL falling edges after a START, counts the bits of each byte, and knows whether the current byte is the address byte or a data byte. Its strobes and levels come from the neighbouring logic: START, STOP, address match, transfer direction, and whether the receive buffer is full or the transmit buffer is empty. The hold points are after the 8th falling edge of a byte (the byte itself) and after the 9th (the ACK/NACK slot).

Software answers a hold through one-cycle clear pulses. There is one for the stretch flag and one for each of the three event flags (address, write data, ack-time). SCL is released only when the stretch flag and every event flag have been cleared. During an address hold, software selects ACK or NACK. The choice is captured when the address flag is cleared and is driven onto SDA in the 9th bit slot. A global disable input and a role input can stop stretching entirely.

The first SCL fall after a START or repeated START belongs to the start condition and is not counted. The next eight falls end data bits 1 to 8, and the fall after them ends the ACK slot.

Top module: `i2cs_stretch_ctrl`

## Requirements
- R1: After reset the stretch flag, all three event flags, the SCL pull-low and the SDA ACK pull-low are all 0.
- R2: Stretching is capable only when `stretch_dis_i` is 0 and `role_i` is 1 (target) or 2 (multi-host). With `role_i` at 0 (host) or 3, or with the disable set, no flag is set and SCL is never pulled.
- R3: With the address hold enable set, the 8th counted fall of the address byte, while `addr_match_i` is 1, sets the address flag and the stretch flag in the same clock edge that samples the fall. SCL is then pulled while it is still low. With no match, nothing is set.
- R4: With the write hold enable set, the 8th counted fall of a data byte in a write transfer to a matched target sets the write flag and the stretch flag.
- R5: On a data byte in a write transfer, a full receive buffer at the 8th fall sets the stretch flag alone. No event flag is set.
- R6: In a read transfer (`rd_xfer_i`=1), an empty transmit buffer at the 8th fall of a matched address byte or of a data byte sets the stretch flag alone.
- R7: With the ack-time hold enable set, the 9th counted fall of a matched address byte or of any data byte sets the ack-time flag and the stretch flag.
- R8: The SCL pull-low stays asserted until the stretch flag and all set event flags are cleared. Clearing the stretch flag alone leaves SCL held while an event flag remains. An event flag falls only on its own clear pulse or on STOP.
- R9: STOP clears all flags, the bit count and the address/selection state at once. START clears the bit count, so that a byte broken off by a repeated START restarts from bit 1.
- R10: When several hold conditions meet at the same fall, each matching event flag is set and a single stretch flag covers them.
- R11: In the ACK slot (after the 8th counted fall) of a matched address byte, or of a data byte in a write transfer, SDA is pulled low unless an address hold is pending or NACK was chosen. The choice is `nack_sel_i`, sampled when the address flag is cleared, and it resets to ACK at each START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL line level |
| start_det_i | input | 1 | START or repeated START strobe |
| stop_det_i | input | 1 | STOP strobe |
| addr_match_i | input | 1 | Received address matches, valid at 8th fall of address byte |
| rd_xfer_i | input | 1 | Transfer direction, 1 = host reads |
| rx_full_i | input | 1 | Receive buffer holds an unread byte |
| tx_empty_i | input | 1 | Transmit buffer has no byte loaded |
| stretch_dis_i | input | 1 | Global stretch disable |
| role_i | input | 2 | 0 host, 1 target, 2 multi-host, 3 reserved |
| adr_hold_en_i | input | 1 | Address hold enable |
| wr_hold_en_i | input | 1 | Write-data hold enable |
| ack_hold_en_i | input | 1 | Ack-time hold enable |
| nack_sel_i | input | 1 | Software ACK (0) / NACK (1) choice for the address byte |
| clr_stretch_i | input | 1 | Clear pulse for the stretch flag |
| clr_adr_i | input | 1 | Clear pulse for the address flag |
| clr_wr_i | input | 1 | Clear pulse for the write flag |
| clr_ack_i | input | 1 | Clear pulse for the ack-time flag |
| scl_pull_o | output | 1 | Open-drain SCL pull-low enable |
| sda_ack_pull_o | output | 1 | Open-drain SDA pull-low enable in the ACK slot |
| stretch_o | output | 1 | Stretch flag |
| adr_flag_o | output | 1 | Address event flag |
| wr_flag_o | output | 1 | Write-data event flag |
| ack_flag_o | output | 1 | Ack-time event flag |

## Verification
The bench goes after the release rule first. If a design freed SCL on the stretch clear alone, a pending address or write flag would no longer hold the bus. The skipped start fall and a repeated START in the middle of a byte are also targeted: if either were miscounted, the holds would land one bit early or late. Simultaneous events are used as well, because a design that kept two stretch flags or dropped an event flag would release after the wrong set of clears. STOP during a hold, NACK capture at release, and the disable and host-role gating are each checked, since a slip there leaves the bus locked or ACKs a byte the software refused.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ROLE_HOST   = 2'd0,
        ROLE_TARGET = 2'd1,
        ROLE_MULTI  = 2'd2,
        ROLE_RSVD   = 2'd3
    } role_e;

    localparam int EVT_N   = 3;
    localparam int EVT_ADR = 0;
    localparam int EVT_WR  = 1;
    localparam int EVT_ACK = 2;

    // Position of the bus within the current byte
    typedef struct packed {
        logic fall8;       // counted fall that ends the last data bit
        logic fall9;       // counted fall that ends the ACK slot
        logic addr_phase;  // current byte is the address byte
        logic selected;    // address matched since the last START
        logic ack_slot;    // between the last data fall and the ACK fall
    } bus_pos_t;

    // Hold requests raised at one fall
    typedef struct packed {
        logic [EVT_N-1:0] evt;
        logic             buf_hold;
    } hold_req_t;

    function automatic logic can_stretch(input logic dis, input logic [1:0] role);
        return !dis && (role == ROLE_TARGET || role == ROLE_MULTI);
    endfunction

endpackage

// File: rtl/i2cs_bit_tracker.sv
module i2cs_bit_tracker
    import i2cs_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     addr_match_i,
    output bus_pos_t pos_o
);
    localparam int CNT_W = $clog2(BYTE_BITS + 2);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(BYTE_BITS);

    logic             scl_q;
    logic             skip_q;
    logic             addr_q;
    logic             sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             fall;
    logic             counted;

    assign fall    = scl_q & ~scl_i & ~start_i & ~stop_i;
    assign counted = fall & ~skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q  <= 1'b1;
            skip_q <= 1'b0;
            addr_q <= 1'b0;
            sel_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            scl_q <= scl_i;
            if (stop_i) begin
                cnt_q  <= '0;
                skip_q <= 1'b0;
                addr_q <= 1'b0;
                sel_q  <= 1'b0;
            end else if (start_i) begin
                cnt_q  <= '0;
                skip_q <= 1'b1;
                addr_q <= 1'b1;
                sel_q  <= 1'b0;
            end else if (fall) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else if (cnt_q == LAST_DATA) begin
                    cnt_q <= ACK_POS;
                    if (addr_q && addr_match_i) sel_q <= 1'b1;
                end else if (cnt_q == ACK_POS) begin
                    cnt_q  <= '0;
                    addr_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        pos_o.fall8      = counted && (cnt_q == LAST_DATA);
        pos_o.fall9      = counted && (cnt_q == ACK_POS);
        pos_o.addr_phase = addr_q;
        pos_o.selected   = sel_q;
        pos_o.ack_slot   = (cnt_q == ACK_POS) && !skip_q;
    end

endmodule

// File: rtl/i2cs_hold_eval.sv
module i2cs_hold_eval
    import i2cs_pkg::*;
(
    input  logic      en_i,
    input  logic      fall8_i,
    input  logic      fall9_i,
    input  logic      addr_phase_i,
    input  logic      selected_i,
    input  logic      addr_match_i,
    input  logic      rd_xfer_i,
    input  logic      rx_full_i,
    input  logic      tx_empty_i,
    input  logic      adr_hold_en_i,
    input  logic      wr_hold_en_i,
    input  logic      ack_hold_en_i,
    output hold_req_t req_o
);
    logic data_rx;
    logic tx_ready_need;

    assign data_rx       = !addr_phase_i && selected_i && !rd_xfer_i;
    assign tx_ready_need = rd_xfer_i && tx_empty_i &&
                           (addr_phase_i ? addr_match_i : selected_i);

    always_comb begin
        req_o.evt[EVT_ADR] = en_i && fall8_i && addr_phase_i && addr_match_i && adr_hold_en_i;
        req_o.evt[EVT_WR]  = en_i && fall8_i && data_rx && wr_hold_en_i;
        req_o.evt[EVT_ACK] = en_i && fall9_i && selected_i && ack_hold_en_i;
        req_o.buf_hold     = en_i && fall8_i && ((data_rx && rx_full_i) || tx_ready_need);
    end

endmodule

// File: rtl/i2cs_flag_bank.sv
module i2cs_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_all_i,
    input  logic [N-1:0] set_evt_i,
    input  logic [N-1:0] clr_evt_i,
    input  logic         set_str_i,
    input  logic         clr_str_i,
    output logic [N-1:0] evt_o,
    output logic         str_o
);
    for (genvar i = 0; i < N; i++) begin : g_evt
        logic q;
        always_ff @(posedge clk) begin
            if (rst || clear_all_i)   q <= 1'b0;
            else if (set_evt_i[i])    q <= 1'b1;
            else if (clr_evt_i[i])    q <= 1'b0;
        end
        assign evt_o[i] = q;
    end

    logic str_q;
    always_ff @(posedge clk) begin
        if (rst || clear_all_i) str_q <= 1'b0;
        else if (set_str_i)     str_q <= 1'b1;
        else if (clr_str_i)     str_q <= 1'b0;
    end
    assign str_o = str_q;

endmodule

// File: rtl/i2cs_stretch_ctrl.sv
module i2cs_stretch_ctrl
    import i2cs_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       start_det_i,
    input  logic       stop_det_i,
    input  logic       addr_match_i,
    input  logic       rd_xfer_i,
    input  logic       rx_full_i,
    input  logic       tx_empty_i,
    input  logic       stretch_dis_i,
    input  logic [1:0] role_i,
    input  logic       adr_hold_en_i,
    input  logic       wr_hold_en_i,
    input  logic       ack_hold_en_i,
    input  logic       nack_sel_i,
    input  logic       clr_stretch_i,
    input  logic       clr_adr_i,
    input  logic       clr_wr_i,
    input  logic       clr_ack_i,
    output logic       scl_pull_o,
    output logic       sda_ack_pull_o,
    output logic       stretch_o,
    output logic       adr_flag_o,
    output logic       wr_flag_o,
    output logic       ack_flag_o
);
    bus_pos_t         pos;
    hold_req_t        req;
    logic             en;
    logic [EVT_N-1:0] evt_q;
    logic [EVT_N-1:0] clr_evt;
    logic             str_q;
    logic             nack_q;
    logic             adr_release;

    assign en = can_stretch(stretch_dis_i, role_i);

    i2cs_bit_tracker #(.BYTE_BITS(BYTE_BITS)) u_track (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_i),
        .start_i      (start_det_i),
        .stop_i       (stop_det_i),
        .addr_match_i (addr_match_i),
        .pos_o        (pos)
    );

    i2cs_hold_eval u_eval (
        .en_i          (en),
        .fall8_i       (pos.fall8),
        .fall9_i       (pos.fall9),
        .addr_phase_i  (pos.addr_phase),
        .selected_i    (pos.selected),
        .addr_match_i  (addr_match_i),
        .rd_xfer_i     (rd_xfer_i),
        .rx_full_i     (rx_full_i),
        .tx_empty_i    (tx_empty_i),
        .adr_hold_en_i (adr_hold_en_i),
        .wr_hold_en_i  (wr_hold_en_i),
        .ack_hold_en_i (ack_hold_en_i),
        .req_o         (req)
    );

    always_comb begin
        clr_evt          = '0;
        clr_evt[EVT_ADR] = clr_adr_i;
        clr_evt[EVT_WR]  = clr_wr_i;
        clr_evt[EVT_ACK] = clr_ack_i;
    end

    i2cs_flag_bank #(.N(EVT_N)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .clear_all_i (stop_det_i),
        .set_evt_i   (req.evt),
        .clr_evt_i   (clr_evt),
        .set_str_i   ((|req.evt) | req.buf_hold),
        .clr_str_i   (clr_stretch_i),
        .evt_o       (evt_q),
        .str_o       (str_q)
    );

    // ACK/NACK choice taken when the address hold is answered
    assign adr_release = evt_q[EVT_ADR] && clr_adr_i && !req.evt[EVT_ADR] && !stop_det_i;

    always_ff @(posedge clk) begin
        if (rst)              nack_q <= 1'b0;
        else if (start_det_i) nack_q <= 1'b0;
        else if (adr_release) nack_q <= nack_sel_i;
    end

    assign scl_pull_o     = en && (str_q || (|evt_q));
    assign sda_ack_pull_o = pos.ack_slot && pos.selected &&
                            (pos.addr_phase || !rd_xfer_i) &&
                            !evt_q[EVT_ADR] && !nack_q;
    assign stretch_o      = str_q;
    assign adr_flag_o     = evt_q[EVT_ADR];
    assign wr_flag_o      = evt_q[EVT_WR];
    assign ack_flag_o     = evt_q[EVT_ACK];

endmodule

// File: rtl/i2cs_stretch_chk.sv
module i2cs_stretch_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       stop_det_i,
    input logic       stretch_dis_i,
    input logic [1:0] role_i,
    input logic       ack_hold_en_i,
    input logic       clr_adr_i,
    input logic       clr_wr_i,
    input logic       scl_pull_o,
    input logic       stretch_o,
    input logic       adr_flag_o,
    input logic       wr_flag_o,
    input logic       ack_flag_o
);
    logic cap;
    assign cap = can_stretch(stretch_dis_i, role_i);

    // R2
    stretch_gated_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stretch_o) |-> $past(cap));

    // R3
    pull_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull_o) |-> !scl_i);

    // R8
    adr_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adr_flag_o) |-> $past(clr_adr_i || stop_det_i));

    // R8
    wr_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_flag_o) |-> $past(clr_wr_i || stop_det_i));

    // R7
    ack_flag_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_flag_o) |-> $past(ack_hold_en_i));

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det_i |=> (!stretch_o && !adr_flag_o && !wr_flag_o && !ack_flag_o));

endmodule

bind i2cs_stretch_ctrl i2cs_stretch_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .stop_det_i    (stop_det_i),
    .stretch_dis_i (stretch_dis_i),
    .role_i        (role_i),
    .ack_hold_en_i (ack_hold_en_i),
    .clr_adr_i     (clr_adr_i),
    .clr_wr_i      (clr_wr_i),
    .scl_pull_o    (scl_pull_o),
    .stretch_o     (stretch_o),
    .adr_flag_o    (adr_flag_o),
    .wr_flag_o     (wr_flag_o),
    .ack_flag_o    (ack_flag_o)
);

// File: tb/i2cs_stretch_ctrl_tb_top.sv
module i2cs_stretch_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, start = 1'b0, stop = 1'b0, match = 1'b0, rd = 1'b0;
    logic rxf = 1'b0, txe = 1'b0, dis = 1'b0;
    logic [1:0] role = 2'd1;
    logic adr_en = 1'b0, wr_en = 1'b0, ack_en = 1'b0, nack_sel = 1'b0;
    logic clr_s = 1'b0, clr_a = 1'b0, clr_w = 1'b0, clr_k = 1'b0;
    logic scl_pull, sda_pull, s_o, a_o, w_o, k_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2cs_stretch_ctrl dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .start_det_i(start), .stop_det_i(stop),
        .addr_match_i(match), .rd_xfer_i(rd), .rx_full_i(rxf), .tx_empty_i(txe),
        .stretch_dis_i(dis), .role_i(role), .adr_hold_en_i(adr_en),
        .wr_hold_en_i(wr_en), .ack_hold_en_i(ack_en), .nack_sel_i(nack_sel),
        .clr_stretch_i(clr_s), .clr_adr_i(clr_a), .clr_wr_i(clr_w), .clr_ack_i(clr_k),
        .scl_pull_o(scl_pull), .sda_ack_pull_o(sda_pull), .stretch_o(s_o),
        .adr_flag_o(a_o), .wr_flag_o(w_o), .ack_flag_o(k_o)
    );

    // Behavioural reference model
    int m_cnt;
    bit m_sclq, m_skip, m_addr, m_sel, m_nack, m_s, m_a, m_w, m_k;

    function automatic bit capable();
        return !dis && (role == 2'd1 || role == 2'd2);
    endfunction

    always @(posedge clk) begin
        bit fall, f8, f9, dat, sa, sw, sk, sb;
        if (rst) begin
            m_cnt = 0; m_sclq = 1; m_skip = 0; m_addr = 0; m_sel = 0;
            m_nack = 0; m_s = 0; m_a = 0; m_w = 0; m_k = 0;
        end else begin
            fall = m_sclq && !scl && !start && !stop;
            f8   = fall && !m_skip && m_cnt == 7;
            f9   = fall && !m_skip && m_cnt == 8;
            dat  = !m_addr && m_sel && !rd;
            sa   = capable() && f8 && m_addr && match && adr_en;
            sw   = capable() && f8 && dat && wr_en;
            sk   = capable() && f9 && m_sel && ack_en;
            sb   = capable() && f8 && ((dat && rxf) || (rd && txe && (m_addr ? match : m_sel)));
            if (stop) begin
                m_s = 0; m_a = 0; m_w = 0; m_k = 0;
                m_cnt = 0; m_skip = 0; m_addr = 0; m_sel = 0;
            end else begin
                if (start) m_nack = 0;
                else if (m_a && clr_a && !sa) m_nack = nack_sel;
                m_a = sa ? 1 : (clr_a ? 0 : m_a);
                m_w = sw ? 1 : (clr_w ? 0 : m_w);
                m_k = sk ? 1 : (clr_k ? 0 : m_k);
                m_s = (sa || sw || sk || sb) ? 1 : (clr_s ? 0 : m_s);
                if (start) begin
                    m_cnt = 0; m_skip = 1; m_addr = 1; m_sel = 0;
                end else if (fall) begin
                    if (m_skip) m_skip = 0;
                    else if (m_cnt == 7) begin
                        m_cnt = 8;
                        if (m_addr && match) m_sel = 1;
                    end else if (m_cnt == 8) begin
                        m_cnt = 0; m_addr = 0;
                    end else m_cnt++;
                end
            end
            m_sclq = scl;
        end
    end

    task automatic cmp(input string req, input string nm, input logic act, input bit exp);
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            total++;
            cmp("R8", "scl_pull", scl_pull, capable() && (m_s || m_a || m_w || m_k));
            cmp("R11", "sda_pull", sda_pull,
                m_cnt == 8 && !m_skip && m_sel && (m_addr || !rd) && !m_a && !m_nack);
            cmp("R10", "stretch", s_o, m_s);
            cmp("R3", "adr_flag", a_o, m_a);
            cmp("R4", "wr_flag", w_o, m_w);
            cmp("R7", "ack_flag", k_o, m_k);
        end
    end

    // Directed checks against values taken from the requirements
    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bits(input int n);
        repeat (n) begin
            scl = 1'b1; tick(4);
            scl = 1'b0; tick(4);
        end
    endtask

    task automatic do_start();
        scl = 1'b1; tick(2);
        start = 1'b1; tick(1); start = 1'b0;
        tick(1);
        scl = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        scl = 1'b1; tick(2);
        stop = 1'b1; tick(1); stop = 1'b0;
        tick(2);
    endtask

    task automatic sw_clear(input bit s, input bit a, input bit w, input bit k);
        clr_s = s; clr_a = a; clr_w = w; clr_k = k;
        tick(1);
        clr_s = 0; clr_a = 0; clr_w = 0; clr_k = 0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1", "stretch", s_o, 0);
        chk("R1", "flags", a_o | w_o | k_o, 0);
        chk("R1", "scl_pull", scl_pull, 0);
        chk("R1", "sda_pull", sda_pull, 0);

        // R3 address hold, then R8 release order and R11 ACK
        adr_en = 1; match = 1; rd = 0;
        do_start();
        bits(8);
        chk("R3", "adr_flag", a_o, 1);
        chk("R3", "stretch", s_o, 1);
        chk("R3", "scl_pull", scl_pull, 1);
        chk("R11", "sda held during adr hold", sda_pull, 0);
        sw_clear(1, 0, 0, 0);
        chk("R8", "pull kept with adr flag", scl_pull, 1);
        nack_sel = 0;
        sw_clear(0, 1, 0, 0);
        chk("R8", "pull released", scl_pull, 0);
        chk("R11", "ack driven", sda_pull, 1);
        bits(1);
        adr_en = 0;

        // R4 write hold on data byte
        wr_en = 1;
        bits(8);
        chk("R4", "wr_flag", w_o, 1);
        chk("R4", "stretch", s_o, 1);
        sw_clear(0, 0, 1, 0);
        chk("R8", "pull kept with stretch", scl_pull, 1);
        sw_clear(1, 0, 0, 0);
        chk("R8", "pull released", scl_pull, 0);
        bits(1);
        wr_en = 0;

        // R5 forced receive-buffer hold
        rxf = 1;
        bits(8);
        chk("R5", "stretch", s_o, 1);
        chk("R5", "no wr_flag", w_o, 0);
        rxf = 0;
        sw_clear(1, 0, 0, 0);
        chk("R5", "released", scl_pull, 0);
        bits(1);

        // R7 ack-time hold at 9th fall
        ack_en = 1;
        bits(8);
        chk("R7", "no hold at 8th", s_o, 0);
        bits(1);
        chk("R7", "ack_flag", k_o, 1);
        chk("R7", "stretch", s_o, 1);
        sw_clear(1, 0, 0, 1);
        chk("R7", "released", scl_pull, 0);
        ack_en = 0;

        // R9 STOP drops a pending hold
        wr_en = 1;
        bits(8);
        chk("R9", "hold before stop", scl_pull, 1);
        do_stop();
        chk("R9", "stop clears pull", scl_pull, 0);
        chk("R9", "stop clears flags", s_o | w_o, 0);
        wr_en = 0;

        // R9 repeated START mid-byte restarts the count
        adr_en = 1;
        do_start();
        bits(5);
        scl = 1'b1; tick(2);
        do_start();
        bits(7);
        chk("R9", "no hold after 7 bits", a_o, 0);
        bits(1);
        chk("R9", "hold after 8 bits", a_o, 1);
        sw_clear(1, 1, 0, 0);
        do_stop();

        // R3 no match, no hold
        match = 0;
        do_start();
        bits(8);
        chk("R3", "no match adr_flag", a_o, 0);
        chk("R3", "no match pull", scl_pull, 0);
        do_stop();

        // R2 disabled and host role
        match = 1; dis = 1;
        do_start();
        bits(8);
        chk("R2", "disabled stretch", s_o, 0);
        chk("R2", "disabled pull", scl_pull, 0);
        do_stop();
        dis = 0; role = 2'd0;
        do_start();
        bits(8);
        chk("R2", "host role stretch", s_o, 0);
        do_stop();
        role = 2'd2;

        // R6 + R10 read address with empty tx buffer and address hold together
        rd = 1; txe = 1; adr_en = 1;
        do_start();
        bits(8);
        chk("R10", "adr_flag", a_o, 1);
        chk("R6", "stretch", s_o, 1);
        chk("R10", "no extra flags", w_o | k_o, 0);
        sw_clear(1, 0, 0, 0);
        chk("R10", "single stretch cleared, adr holds", scl_pull, 1);
        nack_sel = 1;
        sw_clear(0, 1, 0, 0);
        chk("R10", "released", scl_pull, 0);
        chk("R11", "nack leaves sda", sda_pull, 0);
        bits(1);
        adr_en = 0;
        // R6 read data byte, tx empty
        bits(8);
        chk("R6", "data stretch", s_o, 1);
        chk("R6", "no event flag", a_o | w_o | k_o, 0);
        txe = 0;
        sw_clear(1, 0, 0, 0);
        chk("R6", "released", scl_pull, 0);
        bits(1);
        do_stop();
        tick(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule